// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. Its pins are grouped into banks of sixteen, and each pair of banks shares one 32-bit register set. The even bank of a pair uses the low half-word and the odd bank uses the high half-word. Software chooses each pin's direction. It drives output levels only through write-one set and write-one clear registers, so it never has to do a read-modify-write on shared state. It can read back the synchronised level of every pin.

Each pin can report rising edges, falling edges or both. An enabled edge latches a status bit, and software clears that bit by writing a one to it. Each bank has its own level interrupt line. The line is the OR of that bank's sixteen status bits, gated by that bank's bit in a global bank-enable register.

The register bus is a plain strobe interface with no back-pressure. A write takes effect on the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_we` is low. The data stream is the pin levels themselves, sampled on every clock with no handshake. `NUM_BANKS` must be even.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit is 1, so every pin is an input and `pin_oe` is all zeros. Output data, both edge enables, interrupt status and bank enables are all zero. Every `bank_irq` is low.
- R2: Register set k sits at byte address 0x40*(k+1). Its direction register is at offset 0x00, where a 1 makes a pin an input and a 0 makes it an output. `pin_oe` bit n is the inverse of direction bit n, from the cycle after the write.
- R3: Writing the output-set register (offset 0x08) raises each output bit written as 1. Writing the output-clear register (offset 0x0C) lowers each such bit. Bits written as 0 keep their value. The output-data register at offset 0x04 is read-only and ignores writes. `pin_out` follows the output register.
- R4: The input register (offset 0x10) returns the pin levels through a two-flop synchroniser, whatever the pin's direction. A pin change is visible to a read after two clock edges.
- R5: Rising-edge enables are set at offset 0x14 and cleared at 0x18. Falling-edge enables are set at 0x1C and cleared at 0x20. Each of these registers acts on the bits written as 1. A pin may have both enables at once.
- R6: An enabled edge on a synchronised pin sets that pin's status bit (offset 0x24) on the third clock edge after the pin changes. Edges that are not enabled set nothing.
- R7: Writing 1 to a status bit clears it, and bits written as 0 are kept. If a new edge and a clear hit the same bit in the same cycle, the bit stays set.
- R8: Bits 15:0 of set k belong to bank 2k, and bits 31:16 belong to bank 2k+1. `bank_irq[b]` is high exactly when bank b has a status bit set and bank-enable bit b is 1.
- R9: The bank-enable register at byte address 0x08 holds one bit per bank, starting at bit 0. Higher bits are dropped on write and read as 0.
- R10: Reads of unmapped addresses return 0, and writes to them change nothing.
- R11: Reading any set or clear register returns the current value of the register it controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when not selected |
| pin_in | input | NUM_BANKS*16 | Pin levels from the pads |
| pin_out | output | NUM_BANKS*16 | Output levels |
| pin_oe | output | NUM_BANKS*16 | Output enables, 1 drives the pad |
| bank_irq | output | NUM_BANKS | Level interrupt, one per bank |

## Verification
A wrong direction or output bit shows on `pin_oe` or `pin_out` one clock after the write that caused it. A wrong status or bank-enable bit shows on `bank_irq` in the same cycle that it is latched. Wrong synchroniser timing moves the input-register readback and the status latch by one cycle, and a register read taken at the exact cycle exposes that. Comparing every output against a behavioural model on every clock therefore catches most faults within one cycle. Faults in the edge-enable registers show up only at the next toggle of an affected pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned OFF_W    = 6;
  localparam int unsigned BANK_EN_ADDR = 'h08;

  localparam logic [OFF_W-1:0] OFF_DIR      = 6'h00;
  localparam logic [OFF_W-1:0] OFF_OUT      = 6'h04;
  localparam logic [OFF_W-1:0] OFF_OUT_SET  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_OUT_CLR  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_IN       = 6'h10;
  localparam logic [OFF_W-1:0] OFF_RISE_SET = 6'h14;
  localparam logic [OFF_W-1:0] OFF_RISE_CLR = 6'h18;
  localparam logic [OFF_W-1:0] OFF_FALL_SET = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_FALL_CLR = 6'h20;
  localparam logic [OFF_W-1:0] OFF_STAT     = 6'h24;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_q & ~prev_q;
  assign fall_o  = ~lvl_q & prev_q;
endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] level_i,
  input  logic [WORD_W-1:0] rise_i,
  input  logic [WORD_W-1:0] fall_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] dir_o,
  output logic [WORD_W-1:0] out_o,
  output logic [WORD_W-1:0] stat_o
);
  logic [WORD_W-1:0] dir_q, out_q, rise_en_q, fall_en_q, stat_q;
  logic [WORD_W-1:0] hit, w1c;

  assign hit = (rise_i & rise_en_q) | (fall_i & fall_en_q);
  assign w1c = (wr_i && off_i == OFF_STAT) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      stat_q    <= '0;
    end else begin
      stat_q <= (stat_q & ~w1c) | hit;
      if (wr_i) begin
        case (off_i)
          OFF_DIR:      dir_q     <= wdata_i;
          OFF_OUT_SET:  out_q     <= out_q | wdata_i;
          OFF_OUT_CLR:  out_q     <= out_q & ~wdata_i;
          OFF_RISE_SET: rise_en_q <= rise_en_q | wdata_i;
          OFF_RISE_CLR: rise_en_q <= rise_en_q & ~wdata_i;
          OFF_FALL_SET: fall_en_q <= fall_en_q | wdata_i;
          OFF_FALL_CLR: fall_en_q <= fall_en_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off_i)
      OFF_DIR:                    rdata_o = dir_q;
      OFF_OUT, OFF_OUT_SET,
      OFF_OUT_CLR:                rdata_o = out_q;
      OFF_IN:                     rdata_o = level_i;
      OFF_RISE_SET, OFF_RISE_CLR: rdata_o = rise_en_q;
      OFF_FALL_SET, OFF_FALL_CLR: rdata_o = fall_en_q;
      OFF_STAT:                   rdata_o = stat_q;
      default:                    rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign stat_o = stat_q;

  // R3: set write raises the written bits
  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_OUT_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));
  // R3: clear write lowers the written bits
  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_OUT_CLR) |=> ((out_q & $past(wdata_i)) == '0));
  // R3: output only moves on a set or clear write
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && (off_i == OFF_OUT_SET || off_i == OFF_OUT_CLR)) |=> $stable(out_q));
  // R7: a new edge is never lost, even under a clear
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));
  // R6: a status bit only rises because of an enabled edge
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned AW        = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [AW-1:0]             bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  input  logic [NUM_BANKS*16-1:0]   pin_in,
  output logic [NUM_BANKS*16-1:0]   pin_out,
  output logic [NUM_BANKS*16-1:0]   pin_oe,
  output logic [NUM_BANKS-1:0]      bank_irq
);
  localparam int unsigned NPINS   = NUM_BANKS * HALF_W;
  localparam int unsigned NSETS   = NUM_BANKS / 2;
  localparam int unsigned IDX_W   = AW - OFF_W;

  logic [NPINS-1:0]  level, rise, fall, dir_all, stat_all;
  logic [WORD_W-1:0] set_rd [NSETS];
  logic [NSETS-1:0]  set_hit;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic ben_hit;

  gpio_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    assign set_hit[k] = bus_sel && (bus_addr[AW-1:OFF_W] == IDX_W'(k + 1));
    gpio_regset u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(set_hit[k] && bus_we),
      .off_i(bus_addr[OFF_W-1:0]),
      .wdata_i(bus_wdata),
      .level_i(level[k*WORD_W +: WORD_W]),
      .rise_i(rise[k*WORD_W +: WORD_W]),
      .fall_i(fall[k*WORD_W +: WORD_W]),
      .rdata_o(set_rd[k]),
      .dir_o(dir_all[k*WORD_W +: WORD_W]),
      .out_o(pin_out[k*WORD_W +: WORD_W]),
      .stat_o(stat_all[k*WORD_W +: WORD_W])
    );
  end

  assign ben_hit = bus_sel && (bus_addr == AW'(BANK_EN_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_en_q <= '0;
    else if (ben_hit && bus_we) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign bank_irq[b] = bank_en_q[b] && (|stat_all[b*HALF_W +: HALF_W]);
  end

  assign pin_oe = ~dir_all;

  always_comb begin
    bus_rdata = '0;
    if (ben_hit) bus_rdata = WORD_W'(bank_en_q);
    for (int k = 0; k < NSETS; k++)
      if (set_hit[k]) bus_rdata = bus_rdata | set_rd[k];
  end

  // R8: no interrupt from a disabled bank
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_irq & ~bank_en_q) == '0);
  // R9: the bank-enable register takes the low bits of the write
  p_ben_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ben_hit && bus_we) |=> (bank_en_q == $past(bus_wdata[NUM_BANKS-1:0])));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int NB = 4;
  localparam int NP = NB * 16;
  localparam int NS = NB / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] bank_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .AW(8)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  // behavioural reference model
  logic [NP-1:0] m_dir, m_out, m_rise, m_fall, m_stat, m_s1, m_s2, m_prev;
  logic [NB-1:0] m_ben;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_ben = '0;
    end else begin
      logic [NP-1:0] ev, clr;
      ev  = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
      clr = '0;
      if (bus_sel && bus_we) begin
        if (bus_addr == 8'h08) m_ben = bus_wdata[NB-1:0];
        else if (bus_addr >= 8'h40 && int'(bus_addr >> 6) <= NS) begin
          int k;
          k = int'(bus_addr >> 6) - 1;
          case (bus_addr[5:0])
            6'h00: m_dir[k*32 +: 32] = bus_wdata;
            6'h08: m_out[k*32 +: 32] = m_out[k*32 +: 32] | bus_wdata;
            6'h0C: m_out[k*32 +: 32] = m_out[k*32 +: 32] & ~bus_wdata;
            6'h14: m_rise[k*32 +: 32] = m_rise[k*32 +: 32] | bus_wdata;
            6'h18: m_rise[k*32 +: 32] = m_rise[k*32 +: 32] & ~bus_wdata;
            6'h1C: m_fall[k*32 +: 32] = m_fall[k*32 +: 32] | bus_wdata;
            6'h20: m_fall[k*32 +: 32] = m_fall[k*32 +: 32] & ~bus_wdata;
            6'h24: clr[k*32 +: 32] = bus_wdata;
            default: ;
          endcase
        end
      end
      m_stat = (m_stat & ~clr) | ev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int k;
    if (a == 8'h08) return 32'(m_ben);
    if (a < 8'h40 || int'(a >> 6) > NS) return '0;
    k = int'(a >> 6) - 1;
    case (a[5:0])
      6'h00: return m_dir[k*32 +: 32];
      6'h04, 6'h08, 6'h0C: return m_out[k*32 +: 32];
      6'h10: return m_s2[k*32 +: 32];
      6'h14, 6'h18: return m_rise[k*32 +: 32];
      6'h1C, 6'h20: return m_fall[k*32 +: 32];
      6'h24: return m_stat[k*32 +: 32];
      default: return '0;
    endcase
  endfunction

  function automatic logic [NB-1:0] model_irq();
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = m_ben[b] && (|m_stat[b*16 +: 16]);
    return r;
  endfunction

  // every-clock comparison of the output pins
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pin_out !== m_out) begin
        errors++; $display("FAIL R3 pin_out actual %h expected %h", pin_out, m_out);
      end
      checks++;
      if (pin_oe !== ~m_dir) begin
        errors++; $display("FAIL R2 pin_oe actual %h expected %h", pin_oe, ~m_dir);
      end
      checks++;
      if (bank_irq !== model_irq()) begin
        errors++; $display("FAIL R8 bank_irq actual %b expected %b", bank_irq, model_irq());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    exp = model_read(a);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic drive(input logic [NP-1:0] v);
    @(negedge clk); #1;
    pins = v;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h40, "R1"); rd(8'h44, "R1"); rd(8'h64, "R1"); rd(8'h94, "R1");
    rd(8'h08, "R1");
    // R2 direction
    wr(8'h40, 32'hFFFF_0000); rd(8'h40, "R2");
    wr(8'h80, 32'h0F0F_FFFF); rd(8'h80, "R2");
    // R3 set/clear output, R11 readback through the set/clear addresses
    wr(8'h48, 32'h0000_00A5); wr(8'h4C, 32'h0000_0021);
    rd(8'h48, "R11"); rd(8'h4C, "R11"); rd(8'h44, "R3");
    wr(8'h88, 32'h0F00_0001); rd(8'h84, "R3");
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, "R3");
    // R4 synchronised input
    drive(64'h1234_5678_9ABC_DEF0);
    rd(8'h50, "R4");
    idle(2); rd(8'h50, "R4"); rd(8'h90, "R4");
    // R5 edge enables, both kinds on pin 32
    wr(8'h54, 32'h0001_0003); wr(8'h9C, 32'h8000_0001); wr(8'h94, 32'h0000_0001);
    rd(8'h58, "R11"); rd(8'h60, "R11"); rd(8'h94, "R5"); rd(8'h9C, "R5");
    // R6 edges: rise pins 0,1,16 ; fall pin 63 ; pin 32 up then down
    drive(64'h9234_5679_9ABD_DEF3);
    idle(3); rd(8'h64, "R6"); rd(8'hA4, "R6");
    drive(64'h1234_5678_9ABD_DEF3);
    idle(3); rd(8'hA4, "R6");
    // R9 bank enable, upper bits dropped
    wr(8'h08, 32'hFFFF_FFF5); rd(8'h08, "R9");
    wr(8'h08, 32'h0000_000F); rd(8'h08, "R9");
    // R7 partial clear
    wr(8'h64, 32'h0000_0001); rd(8'h64, "R7");
    wr(8'hA4, 32'h8000_0000); rd(8'hA4, "R7");
    // R7 edge and clear in the same cycle on pin 1
    drive(64'h1234_5678_9ABD_DEF1);
    idle(3);
    drive(64'h1234_5678_9ABD_DEF3);
    idle(1);
    wr(8'h64, 32'h0000_0002);
    rd(8'h64, "R7");
    // R5 disable rising on pin 16 then toggle it
    wr(8'h58, 32'h0001_0000);
    wr(8'h64, 32'hFFFF_FFFF);
    drive(64'h1234_5678_9ABC_DEF3);
    idle(1);
    drive(64'h1234_5678_9ABD_DEF3);
    idle(4); rd(8'h64, "R5"); rd(8'h58, "R5");
    // R10 unmapped addresses
    wr(8'h00, 32'hFFFF_FFFF); wr(8'hC0, 32'hFFFF_FFFF); wr(8'h68, 32'hFFFF_FFFF);
    rd(8'h00, "R10"); rd(8'h3C, "R10"); rd(8'hC0, "R10"); rd(8'h68, "R10");
    rd(8'h40, "R10"); rd(8'h08, "R10");
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule